// File: doc/BRIEF.md
# CAN Bit Stuffing and CRC Engine

This block does the bit-level processing for one CAN 2.0B node. It works between the frame sequencer, which builds and parses frames field by field, and the bit timing logic, which produces one sample tick per bus bit. There are two independent lanes. The transmit lane takes one frame bit from the sequencer on each transmit tick. It drives the bus bit, inserts stuff bits and sends the 15-bit CRC that it has computed itself. It tells the sequencer with a take strobe whether the frame bit was used.

The receive lane takes one sampled bus bit on each receive tick. It removes stuff bits and reports stuffing violations. It recomputes the CRC over the frame, checks the received CRC sequence against it, and checks fixed-form bits against a value that the sequencer supplies. The sequencer labels every bit with a field code. That code decides which operations apply to the bit: CRC, stuffing, form check, or plain pass-through.

Top module: `can_bitstream_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `tx_bus_bit` is 1 (recessive). With no tick, `tx_take`, `rx_data_valid`, `rx_stuff_err`, `rx_crc_err` and `rx_form_err` are 0.
- R2: Five consecutive equal bus bits in the stuffed region cause a stuff bit. The transmit tick after them drives the opposite value, and `tx_take` is 0 on that tick. The stuff bit counts as the first bit of a new run.
- R3: The transmit CRC uses polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (0x4599) and starts from zero at the SOF bit. It covers the SOF and BODY bits. During CRC-field ticks the lane sends the CRC most significant bit first and ignores `tx_frame_bit`, with `tx_take` high on each of these ticks.
- R4: The stuffed region runs from SOF to the last CRC bit. A stuff bit that falls due after the final CRC bit is still sent on the next tick, even though the field code has already moved on.
- R5: Stuff bits are left out of the CRC in both lanes. A correctly stuffed frame whose CRC was computed over the unstuffed bits therefore checks clean on receive.
- R6: A receive tick that carries an expected stuff bit produces no data. Every other receive tick whose field is not IDLE sets `rx_data_valid` with the sampled bit on `rx_data_bit`.
- R7: If the bit expected as a stuff bit equals the five bits before it (six equal bits in the stuffed region), `rx_stuff_err` pulses for that bit.
- R8: The receive CRC is computed over SOF, BODY and the received CRC bits. On the first non-stuff tick after the CRC field, `rx_crc_err` pulses if the remainder is not zero.
- R9: On a FIXED-field receive tick, `rx_form_err` pulses if the bit differs from `rx_fixed_val`.
- R10: FIXED and RAW bits are never stuffed, never trigger a stuff check, and pass `tx_frame_bit` straight to the bus. Long runs in these fields raise no error.
- R11: Field codes on `tx_field`/`rx_field` are IDLE=0, SOF=1, BODY=2, CRC=3, FIXED=4, RAW=5. All lane outputs except `tx_take` are registered and show the result of a tick on the following cycle. `tx_take` is combinational within the tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_tick | input | 1 | Transmit bit slot strobe |
| tx_field | input | 3 | Field code of the pending transmit bit |
| tx_frame_bit | input | 1 | Frame bit offered by the sequencer |
| tx_bus_bit | output | 1 | Bit driven toward the transceiver |
| tx_take | output | 1 | The offered frame bit (or CRC slot) was consumed this tick |
| rx_tick | input | 1 | Receive sample strobe |
| rx_field | input | 3 | Field code of the sampled bit |
| rx_bus_bit | input | 1 | Sampled bus bit |
| rx_fixed_val | input | 1 | Expected value of a fixed-form bit |
| rx_data_bit | output | 1 | Destuffed bit toward the deserializer |
| rx_data_valid | output | 1 | rx_data_bit is valid |
| rx_stuff_err | output | 1 | Stuffing violation pulse |
| rx_crc_err | output | 1 | CRC mismatch pulse |
| rx_form_err | output | 1 | Fixed-form bit violation pulse |

## Verification
Some properties can be judged from a single cycle and are checked by assertions on every cycle. These are: a stuff bit always inverts the previous bus bit, FIXED and RAW bits pass through unchanged, stuff ticks never produce receive data, a stuff error only follows an expected stuff slot, form errors only follow FIXED ticks, and CRC errors only follow the CRC field. Other behaviour depends on whole frames and only the bench scenarios can show it. This covers the exact stuffed transmit stream including the CRC value and stuffing after the final CRC bit, the destuffed receive data, a clean CRC check on good frames, and detection of corrupted frames. The bench sweeps body lengths and bit patterns, including runs of exactly five, and computes every expected stream independently.

// File: rtl/can_bs_pkg.sv
// Shared constants and field codes for the CAN bitstream engine.
// Assumes: the sequencer drives one of the codes below with every tick.
package can_bs_pkg;

    localparam int FLD_W        = 3;
    localparam int CRC_W_DEF    = 15;
    localparam logic [14:0] CRC_POLY_DEF = 15'h4599;
    localparam int RUN_LIMIT_DEF = 5;

    typedef enum logic [FLD_W-1:0] {
        FLD_IDLE  = 3'd0,
        FLD_SOF   = 3'd1,
        FLD_BODY  = 3'd2,
        FLD_CRC   = 3'd3,
        FLD_FIXED = 3'd4,
        FLD_RAW   = 3'd5
    } fld_t;

endpackage

// File: rtl/can_crc_reg.sv
// CRC shift register: restart with a first bit, accumulate, or shift out.
// Assumes: at most one of start/calc/shift is high per cycle.
module can_crc_reg #(
    parameter int            W    = 15,
    parameter logic [W-1:0]  POLY = 15'h4599
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         calc,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] crc
);

    // One polynomial division step over a single input bit.
    function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic b);
        logic [W-1:0] n;
        n = {c[W-2:0], 1'b0};
        if (b ^ c[W-1]) n = n ^ POLY;
        return n;
    endfunction

    // Register update: restart from zero, accumulate, or shift out MSB-first.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc <= '0;
        else if (start)  crc <= step('0, bit_in);
        else if (calc)   crc <= step(crc, bit_in);
        else if (shift)  crc <= {crc[W-2:0], 1'b0};
    end

    p_single_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start, calc, shift}));

    p_shift_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> crc[W-1] == $past(crc[W-2]));

endmodule

// File: rtl/can_run_tracker.sv
// Tracks the length of the current run of equal bits and predicts whether
// the bit being applied now completes a run of LIMIT.
// Assumes: LIMIT >= 2, so a stuff bit can never itself complete a run.
module can_run_tracker #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic advance,
    input  logic bit_in,
    output logic last_bit,
    output logic limit_next
);

    localparam int SAT = LIMIT + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] run_len;
    logic [CW-1:0] run_nxt;

    // Next run length if the current bit is applied.
    always_comb begin
        if (start || bit_in != last_bit) run_nxt = CW'(1);
        else if (run_len < CW'(SAT))     run_nxt = run_len + CW'(1);
        else                             run_nxt = run_len;
        limit_next = (run_nxt == CW'(LIMIT));
    end

    // Commit the run state when a bit is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len  <= '0;
            last_bit <= 1'b1;
        end else if (start || advance) begin
            run_len  <= run_nxt;
            last_bit <= bit_in;
        end
    end

    p_run_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= CW'(SAT));

endmodule

// File: rtl/can_tx_path.sv
// Transmit lane: picks the bus bit for each tick (frame bit, CRC bit or
// stuff bit), keeps the CRC and the stuff run, and reports consumption.
// Assumes: the sequencer holds the same field/bit until tx_take is seen.
module can_tx_path import can_bs_pkg::*; #(
    parameter int                CRC_W     = CRC_W_DEF,
    parameter logic [CRC_W-1:0]  CRC_POLY  = CRC_POLY_DEF,
    parameter int                RUN_LIMIT = RUN_LIMIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [FLD_W-1:0] field,
    input  logic             bit_in,
    output logic             bus_bit,
    output logic             take
);

    fld_t             fld;
    logic             stuff_pend;
    logic             stuffed_fld;
    logic             emit;
    logic             crc_start, crc_calc, crc_shift;
    logic             trk_start, trk_adv;
    logic             last_bit, limit_next;
    logic [CRC_W-1:0] crc;

    assign fld         = fld_t'(field);
    assign stuffed_fld = (fld == FLD_SOF) || (fld == FLD_BODY) || (fld == FLD_CRC);
    assign take        = tick && !stuff_pend;

    // Choose the bit for this slot and which trackers it feeds.
    always_comb begin
        emit      = bit_in;
        crc_start = 1'b0;
        crc_calc  = 1'b0;
        crc_shift = 1'b0;
        trk_start = 1'b0;
        trk_adv   = 1'b0;
        if (tick) begin
            if (stuff_pend) begin
                emit    = !last_bit;
                trk_adv = 1'b1;
            end else begin
                case (fld)
                    FLD_SOF: begin
                        crc_start = 1'b1;
                        trk_start = 1'b1;
                    end
                    FLD_BODY: begin
                        crc_calc = 1'b1;
                        trk_adv  = 1'b1;
                    end
                    FLD_CRC: begin
                        emit      = crc[CRC_W-1];
                        crc_shift = 1'b1;
                        trk_adv   = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    can_crc_reg #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (crc_start),
        .calc   (crc_calc),
        .shift  (crc_shift),
        .bit_in (emit),
        .crc    (crc)
    );

    can_run_tracker #(.LIMIT(RUN_LIMIT)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (trk_start),
        .advance    (trk_adv),
        .bit_in     (emit),
        .last_bit   (last_bit),
        .limit_next (limit_next)
    );

    // Drive the bus and arm a stuff bit after a full run in the stuffed region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_bit    <= 1'b1;
            stuff_pend <= 1'b0;
        end else if (tick) begin
            bus_bit    <= emit;
            stuff_pend <= !stuff_pend && stuffed_fld && limit_next;
        end
    end

    p_stuff_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stuff_pend) |=> (bus_bit != $past(bus_bit)));

    p_unstuffed_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stuff_pend && (fld == FLD_FIXED || fld == FLD_RAW))
            |=> (bus_bit == $past(bit_in)));

endmodule

// File: rtl/can_rx_path.sv
// Receive lane: drops stuff bits, flags stuffing, CRC and form violations,
// and hands destuffed bits to the deserializer.
// Assumes: the field code describes the destuffed bit; it is ignored on
// ticks that carry an expected stuff bit.
module can_rx_path import can_bs_pkg::*; #(
    parameter int                CRC_W     = CRC_W_DEF,
    parameter logic [CRC_W-1:0]  CRC_POLY  = CRC_POLY_DEF,
    parameter int                RUN_LIMIT = RUN_LIMIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [FLD_W-1:0] field,
    input  logic             bit_in,
    input  logic             fixed_val,
    output logic             data_bit,
    output logic             data_valid,
    output logic             stuff_err,
    output logic             crc_err,
    output logic             form_err
);

    fld_t             fld;
    logic             stuff_exp;
    logic             crc_armed;
    logic             stuffed_fld;
    logic             data_tick;
    logic             crc_start, crc_calc;
    logic             trk_start, trk_adv;
    logic             last_bit, limit_next;
    logic [CRC_W-1:0] crc;

    assign fld         = fld_t'(field);
    assign stuffed_fld = (fld == FLD_SOF) || (fld == FLD_BODY) || (fld == FLD_CRC);
    assign data_tick   = tick && !stuff_exp && (fld != FLD_IDLE);

    // Route the sampled bit to the CRC and run trackers.
    always_comb begin
        crc_start = 1'b0;
        crc_calc  = 1'b0;
        trk_start = 1'b0;
        trk_adv   = 1'b0;
        if (tick) begin
            if (stuff_exp) begin
                trk_adv = 1'b1;
            end else begin
                case (fld)
                    FLD_SOF: begin
                        crc_start = 1'b1;
                        trk_start = 1'b1;
                    end
                    FLD_BODY, FLD_CRC: begin
                        crc_calc = 1'b1;
                        trk_adv  = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    can_crc_reg #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (crc_start),
        .calc   (crc_calc),
        .shift  (1'b0),
        .bit_in (bit_in),
        .crc    (crc)
    );

    can_run_tracker #(.LIMIT(RUN_LIMIT)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (trk_start),
        .advance    (trk_adv),
        .bit_in     (bit_in),
        .last_bit   (last_bit),
        .limit_next (limit_next)
    );

    // Stuff expectation and CRC-check arming follow each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuff_exp <= 1'b0;
            crc_armed <= 1'b0;
        end else if (tick) begin
            stuff_exp <= !stuff_exp && stuffed_fld && limit_next;
            if (!stuff_exp) crc_armed <= (fld == FLD_CRC);
        end
    end

    // Registered data and error pulses for the tick just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_bit   <= 1'b1;
            data_valid <= 1'b0;
            stuff_err  <= 1'b0;
            crc_err    <= 1'b0;
            form_err   <= 1'b0;
        end else begin
            data_valid <= data_tick;
            if (data_tick) data_bit <= bit_in;
            stuff_err  <= tick && stuff_exp && (bit_in == last_bit);
            crc_err    <= tick && !stuff_exp && crc_armed && (fld != FLD_CRC)
                          && (crc != '0);
            form_err   <= tick && !stuff_exp && (fld == FLD_FIXED)
                          && (bit_in != fixed_val);
        end
    end

    p_no_data_on_stuff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stuff_exp) |=> !data_valid);

    p_stuff_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> $past(stuff_exp && tick));

    p_form_only_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        form_err |-> ($past(field) == FLD_FIXED));

    p_crc_check_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> $past(crc_armed));

endmodule

// File: rtl/can_bitstream_unit.sv
// Top of the CAN bitstream engine: an independent transmit lane and
// receive lane sharing field codes and CRC/stuffing parameters.
// Assumes: ticks come from bit timing logic, field codes from the sequencer.
module can_bitstream_unit import can_bs_pkg::*; #(
    parameter int                CRC_W     = CRC_W_DEF,
    parameter logic [CRC_W-1:0]  CRC_POLY  = CRC_POLY_DEF,
    parameter int                RUN_LIMIT = RUN_LIMIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_tick,
    input  logic [FLD_W-1:0] tx_field,
    input  logic             tx_frame_bit,
    output logic             tx_bus_bit,
    output logic             tx_take,
    input  logic             rx_tick,
    input  logic [FLD_W-1:0] rx_field,
    input  logic             rx_bus_bit,
    input  logic             rx_fixed_val,
    output logic             rx_data_bit,
    output logic             rx_data_valid,
    output logic             rx_stuff_err,
    output logic             rx_crc_err,
    output logic             rx_form_err
);

    can_tx_path #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .RUN_LIMIT(RUN_LIMIT)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tx_tick),
        .field   (tx_field),
        .bit_in  (tx_frame_bit),
        .bus_bit (tx_bus_bit),
        .take    (tx_take)
    );

    can_rx_path #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .RUN_LIMIT(RUN_LIMIT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (rx_tick),
        .field      (rx_field),
        .bit_in     (rx_bus_bit),
        .fixed_val  (rx_fixed_val),
        .data_bit   (rx_data_bit),
        .data_valid (rx_data_valid),
        .stuff_err  (rx_stuff_err),
        .crc_err    (rx_crc_err),
        .form_err   (rx_form_err)
    );

endmodule

// File: tb/can_bitstream_unit_test.sv
// Bench: sweeps body lengths and patterns, building expected stuffed streams
// and CRCs arithmetically, then checks both lanes and error detection.
module can_bitstream_unit_test;

    // Field codes as stated in R11.
    localparam logic [2:0] F_IDLE = 3'd0, F_SOF = 3'd1, F_BODY = 3'd2,
                           F_CRC = 3'd3, F_FIXED = 3'd4, F_RAW = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_tick = 1'b0, tx_frame_bit = 1'b1;
    logic [2:0] tx_field = F_IDLE;
    logic tx_bus_bit, tx_take;
    logic rx_tick = 1'b0, rx_bus_bit = 1'b1, rx_fixed_val = 1'b1;
    logic [2:0] rx_field = F_IDLE;
    logic rx_data_bit, rx_data_valid, rx_stuff_err, rx_crc_err, rx_form_err;

    always #2 clk = ~clk;

    can_bitstream_unit uut (
        .clk(clk), .rst_n(rst_n),
        .tx_tick(tx_tick), .tx_field(tx_field), .tx_frame_bit(tx_frame_bit),
        .tx_bus_bit(tx_bus_bit), .tx_take(tx_take),
        .rx_tick(rx_tick), .rx_field(rx_field), .rx_bus_bit(rx_bus_bit),
        .rx_fixed_val(rx_fixed_val), .rx_data_bit(rx_data_bit),
        .rx_data_valid(rx_data_valid), .rx_stuff_err(rx_stuff_err),
        .rx_crc_err(rx_crc_err), .rx_form_err(rx_form_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit         ub[0:255];
    logic [2:0] uf[0:255];
    int         ulen;
    bit         sb[0:319];
    logic [2:0] sf[0:319];
    bit         ss[0:319];
    int         slen;
    bit         rd[0:319];
    int         rlen, first_stuff;
    bit         saw_stuff, saw_crc, saw_form;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [14:0] crc_upto(input int n);
        logic [14:0] c = '0;
        for (int i = 0; i < n; i++) begin
            logic fb = ub[i] ^ c[14];
            c = {c[13:0], 1'b0};
            if (fb) c = c ^ 15'h4599;
        end
        return c;
    endfunction

    task automatic push_u(input bit b, input logic [2:0] f);
        ub[ulen] = b; uf[ulen] = f; ulen++;
    endtask

    // Unstuffed frame: SOF, body, CRC, then delimiter/ack/EOF tail.
    task automatic build(input int len, input int kind);
        logic [14:0] c;
        ulen = 0;
        push_u(1'b0, F_SOF);
        for (int i = 0; i < len; i++) begin
            bit b;
            case (kind)
                0: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    b = lfsr[0];
                end
                1: b = 1'b0;
                2: b = 1'b1;
                default: b = ((i / 5) % 2) != 0;
            endcase
            push_u(b, F_BODY);
        end
        c = crc_upto(ulen);
        for (int k = 14; k >= 0; k--) push_u(c[k], F_CRC);
        push_u(1'b1, F_FIXED);
        push_u(1'b1, F_RAW);
        for (int k = 0; k < 8; k++) push_u(1'b1, F_FIXED);
    endtask

    // Stuffing per R2/R4/R10.
    task automatic restuff();
        int run = 0;
        bit last = 1'b0, pend = 1'b0;
        slen = 0;
        for (int i = 0; i < ulen; i++) begin
            if (pend) begin
                sb[slen] = ~last; sf[slen] = uf[i]; ss[slen] = 1'b1; slen++;
                last = ~last; run = 1; pend = 1'b0;
            end
            sb[slen] = ub[i]; sf[slen] = uf[i]; ss[slen] = 1'b0; slen++;
            if (uf[i] == F_SOF || uf[i] == F_BODY || uf[i] == F_CRC) begin
                if (uf[i] == F_SOF || ub[i] != last) run = 1;
                else run++;
                last = ub[i];
                pend = (run == 5);
            end else pend = 1'b0;
        end
    endtask

    task automatic run_tx();
        bit got[0:319];
        int k = 0, bad_bits = 0, bad_take = 0;
        for (int j = 0; j < slen; j++) begin
            @(negedge clk);
            if (j > 0) got[j-1] = tx_bus_bit;
            tx_tick = 1'b1;
            tx_field = (k < ulen) ? uf[k] : F_IDLE;
            tx_frame_bit = (k < ulen) ? ((uf[k] == F_CRC) ? ~ub[k] : ub[k]) : 1'b1;
            #1;
            if (tx_take == ss[j]) bad_take++;
            if (tx_take) k++;
        end
        @(negedge clk);
        got[slen-1] = tx_bus_bit;
        tx_tick = 1'b0;
        for (int j = 0; j < slen; j++) if (got[j] != sb[j]) bad_bits++;
        chk(bad_bits == 0, "R2 R3 R4 R5 R10 R11", "tx stream bit mismatches", bad_bits, 0);
        chk(bad_take == 0 && k == ulen, "R2 R3", "tx_take mismatches", bad_take, 0);
    endtask

    task automatic sample_rx(input int idx);
        if (rx_data_valid) begin rd[rlen] = rx_data_bit; rlen++; end
        if (rx_stuff_err) begin
            if (!saw_stuff) first_stuff = idx;
            saw_stuff = 1'b1;
        end
        if (rx_crc_err)  saw_crc = 1'b1;
        if (rx_form_err) saw_form = 1'b1;
    endtask

    task automatic run_rx(input int flip_idx);
        rlen = 0; first_stuff = -1;
        saw_stuff = 1'b0; saw_crc = 1'b0; saw_form = 1'b0;
        for (int j = 0; j < slen; j++) begin
            @(negedge clk);
            if (j > 0) sample_rx(j - 1);
            rx_tick = 1'b1;
            rx_field = sf[j];
            rx_bus_bit = sb[j] ^ (j == flip_idx);
            rx_fixed_val = 1'b1;
        end
        @(negedge clk);
        sample_rx(slen - 1);
        rx_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held and right after release
        chk(tx_bus_bit == 1'b1, "R1", "tx_bus_bit in reset", tx_bus_bit, 1);
        chk(tx_take == 1'b0 && rx_data_valid == 1'b0, "R1", "take/valid in reset",
            tx_take | rx_data_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rx_stuff_err, rx_crc_err, rx_form_err} == 3'b000, "R1",
            "error flags after reset", {rx_stuff_err, rx_crc_err, rx_form_err}, 0);
        chk(tx_bus_bit == 1'b1, "R1", "tx_bus_bit after reset", tx_bus_bit, 1);

        // R7: wrong stuff bit after SOF + four zeros (stuff at index 5)
        build(10, 1);
        restuff();
        chk(ss[5] == 1'b1, "R7", "bench stuff position", ss[5], 1);
        run_rx(5);
        chk(saw_stuff && first_stuff == 5, "R7", "stuff error bit index", first_stuff, 5);

        // R9: corrupt last EOF bit
        build(12, 0);
        restuff();
        run_rx(slen - 1);
        chk(saw_form, "R9", "form error on bad fixed bit", saw_form, 1);
        chk(!saw_stuff && !saw_crc, "R9", "no other errors", saw_stuff | saw_crc, 0);

        for (int kind = 0; kind < 4; kind++) begin
            for (int len = 1; len <= 40; len++) begin
                int bad_data;
                build(len, kind);
                restuff();
                run_tx();
                run_rx(-1);
                bad_data = (rlen == ulen) ? 0 : 1000;
                for (int i = 0; i < ulen && i < rlen; i++) if (rd[i] != ub[i]) bad_data++;
                chk(bad_data == 0, "R6 R5", "rx destuffed data mismatches", bad_data, 0);
                chk(!saw_stuff && !saw_crc && !saw_form, "R8 R10 R5", "errors on clean frame",
                    {saw_stuff, saw_crc, saw_form}, 0);
                // R8: single body bit flipped, CRC kept
                ub[1] = ~ub[1];
                restuff();
                run_rx(-1);
                chk(saw_crc && !saw_stuff && !saw_form, "R8", "crc error on corrupted frame",
                    {saw_stuff, saw_crc, saw_form}, 3'b010);
            end
        end

        summary();
        $finish;
    end

endmodule